// File: doc/BRIEF.md
# Link Fault and Transition Monitor

This block sits on one receive channel after character recovery and decides whether the link is usable. On each character clock it takes a 10-bit recovered character and three status bits that other logic produces: a recovered-rate frequency alarm, a low-amplitude alarm and a channel-disabled flag. From the characters it keeps track of how many bit times have gone by without any bit transition. A long quiet stretch raises an internal transition fault.

The transition fault has asymmetric hysteresis. It sets as soon as 60 bit times go by without a transition. It only clears once three characters in a row each show at least one transition. Bit changes across a character boundary count as well as those inside a character.

The active-low fault output is low whenever the transition fault or any of the three status alarms is present. External logic can use it to switch to a redundant serial input or to discard received data.

Top module: `link_fault_monitor`

## Requirements
- R1: An asynchronous active-low reset drives `faultN` low, sets the transition fault and clears the quiet-bit run and the good-character count. A single character with transitions after reset does not clear the fault.
- R2: `charIn[0]` is the earliest received bit and `charIn[9]` the latest. A difference between the previous character's bit 9 and the current bit 0 counts as a transition.
- R3: The transition fault sets on the edge at which the run of bit times without a transition reaches 60. The run saturates at 60.
- R4: A character that contains a transition restarts the run at the number of bit boundaries after its last transition, which is 9 minus the index of the last change.
- R5: While set, the transition fault clears on the edge that captures the third consecutive character containing a transition.
- R6: While the transition fault is set, a character with no transition resets the count of consecutive good characters to zero.
- R7: `freqBad` high at a clock edge makes `faultN` low after that edge.
- R8: `ampLow` high at a clock edge makes `faultN` low after that edge.
- R9: `chanOff` high at a clock edge makes `faultN` low after that edge, whatever the character stream does.
- R10: `faultN` changes only at a rising clock edge. It is high only when the transition fault and all three alarms sampled at that edge are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| charIn | input | 10 | Recovered character, bit 0 received first |
| freqBad | input | 1 | Recovered frequency outside allowed range |
| ampLow | input | 1 | Signal amplitude below threshold |
| chanOff | input | 1 | Receive channel disabled |
| faultN | output | 1 | Link fault, active low |

## Verification
The assertions assume that the three status bits and the character are stable around each rising clock edge. They also assume that reset is held long enough for the state to settle. The bench changes every input only on the falling edge, and it asserts and releases reset on the falling edge as well. It never changes an input near the sampling edge. The checks on the clearing streak and on the fault setting rely on a character arriving on every clock, and the bench supplies one on every cycle.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Strobes the datapath hands to the control each character
  typedef struct packed {
    logic hasTrans;  // current character shows at least one bit change
    logic runHit;    // quiet run reaches the loss limit with this character
  } lfm_strobe_t;

  typedef enum logic {
    ST_CLEAR = 1'b0,
    ST_FAULT = 1'b1
  } lfm_state_t;

endpackage

// File: rtl/lfm_datapath.sv
module lfm_datapath
  import lfm_pkg::*;
#(
  parameter int CHAR_W    = 10,
  parameter int RUN_LIMIT = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] charIn,
  output lfm_strobe_t       strobes
);

  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam int SUM_W = RUN_W + 1;

  logic              prevLast;
  logic [RUN_W-1:0]  runCount;
  logic [RUN_W-1:0]  runNext;
  logic [SUM_W-1:0]  runSum;
  logic [CHAR_W-1:0] edges;
  int                lastPos;

  // edges[i]: bit i differs from the bit received just before it
  generate
    for (genvar i = 0; i < CHAR_W; i++) begin : g_edge
      if (i == 0) begin : g_first
        assign edges[i] = charIn[0] ^ prevLast;
      end else begin : g_inner
        assign edges[i] = charIn[i] ^ charIn[i-1];
      end
    end
  endgenerate

  // Latest position holding a change
  always_comb begin
    lastPos = 0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (edges[i]) lastPos = i;
    end
  end

  always_comb begin
    runSum = {1'b0, runCount} + SUM_W'(CHAR_W);
    if (|edges) begin
      runNext = RUN_W'(CHAR_W - 1 - lastPos);
    end else if (runSum >= SUM_W'(RUN_LIMIT)) begin
      runNext = RUN_W'(RUN_LIMIT);
    end else begin
      runNext = runSum[RUN_W-1:0];
    end
    strobes.hasTrans = |edges;
    strobes.runHit   = (runNext >= RUN_W'(RUN_LIMIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLast <= 1'b0;
      runCount <= '0;
    end else begin
      prevLast <= charIn[CHAR_W-1];
      runCount <= runNext;
    end
  end

endmodule

// File: rtl/lfm_control.sv
module lfm_control
  import lfm_pkg::*;
#(
  parameter int GOOD_NEED = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  lfm_strobe_t strobes,
  output logic        txFault
);

  localparam int GOOD_W = $clog2(GOOD_NEED + 1);

  lfm_state_t        state, stateNext;
  logic [GOOD_W-1:0] goodCount, goodNext;

  always_comb begin
    stateNext = state;
    goodNext  = goodCount;
    unique case (state)
      ST_CLEAR: begin
        goodNext = '0;
        if (strobes.runHit) stateNext = ST_FAULT;
      end
      ST_FAULT: begin
        if (!strobes.hasTrans) begin
          goodNext = '0;
        end else if (goodCount == GOOD_W'(GOOD_NEED - 1)) begin
          goodNext  = '0;
          stateNext = ST_CLEAR;
        end else begin
          goodNext = goodCount + 1'b1;
        end
      end
      default: stateNext = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_FAULT;
      goodCount <= '0;
    end else begin
      state     <= stateNext;
      goodCount <= goodNext;
    end
  end

  assign txFault = (state == ST_FAULT);

endmodule

// File: rtl/link_fault_monitor.sv
module link_fault_monitor
  import lfm_pkg::*;
#(
  parameter int CHAR_W    = 10,
  parameter int RUN_LIMIT = 60,
  parameter int GOOD_NEED = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] charIn,
  input  logic              freqBad,
  input  logic              ampLow,
  input  logic              chanOff,
  output logic              faultN
);

  localparam int ALARM_N = 3;

  lfm_strobe_t        strobes;
  logic               txFault;
  logic [ALARM_N-1:0] alarmQ;

  lfm_datapath #(
    .CHAR_W   (CHAR_W),
    .RUN_LIMIT(RUN_LIMIT)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .charIn (charIn),
    .strobes(strobes)
  );

  lfm_control #(
    .GOOD_NEED(GOOD_NEED)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .txFault(txFault)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alarmQ <= '0;
    else       alarmQ <= {chanOff, ampLow, freqBad};
  end

  // Driven only from flops: changes on clock edges alone
  assign faultN = ~(txFault | (|alarmQ));

endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
  parameter int GOOD_NEED = 3
) (
  input logic clk,
  input logic rstN,
  input logic freqBad,
  input logic ampLow,
  input logic chanOff,
  input logic faultN,
  input logic txFault,
  input logic hasTrans,
  input logic runHit
);

  localparam int STREAK_W = $clog2(GOOD_NEED + 1);

  logic [STREAK_W-1:0] streak;

  // Consecutive characters with a change, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 streak <= '0;
    else if (!hasTrans)                        streak <= '0;
    else if (streak != STREAK_W'(GOOD_NEED))   streak <= streak + 1'b1;
  end

  p_freq_forces_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    freqBad |=> !faultN);

  p_amp_forces_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    ampLow |=> !faultN);

  p_off_forces_fault_r9: assert property (@(posedge clk) disable iff (!rstN)
    chanOff |=> !faultN);

  p_set_needs_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFault) |-> $past(runHit));

  p_clear_needs_streak_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFault) |-> (streak >= STREAK_W'(GOOD_NEED)));

  p_quiet_char_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txFault && !hasTrans) |=> txFault);

endmodule

bind link_fault_monitor lfm_checker #(.GOOD_NEED(GOOD_NEED)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .freqBad (freqBad),
  .ampLow  (ampLow),
  .chanOff (chanOff),
  .faultN  (faultN),
  .txFault (txFault),
  .hasTrans(strobes.hasTrans),
  .runHit  (strobes.runHit)
);

// File: tb/tb_link_fault_monitor.sv
module tb_link_fault_monitor;

  localparam int PERIOD  = 10;
  localparam int NUM_VEC = 25;

  // {req[3:0], expFaultN, chanOff, ampLow, freqBad, char[9:0]}
  localparam logic [17:0] VEC [NUM_VEC] = '{
    {4'd5, 1'b0, 3'b000, 10'h155},  // R5 good 1
    {4'd5, 1'b0, 3'b000, 10'h155},  // R5 good 2
    {4'd5, 1'b1, 3'b000, 10'h155},  // R5 third clears
    {4'd7, 1'b0, 3'b001, 10'h2AA},  // R7 frequency alarm
    {4'd8, 1'b0, 3'b010, 10'h2AA},  // R8 amplitude alarm
    {4'd9, 1'b0, 3'b100, 10'h2AA},  // R9 channel off
    {4'd10, 1'b1, 3'b000, 10'h2AA}, // R10 all clear, run 0
    {4'd3, 1'b1, 3'b000, 10'h3FF},  // R3 run 10
    {4'd3, 1'b1, 3'b000, 10'h3FF},  // R3 run 20
    {4'd3, 1'b1, 3'b000, 10'h3FF},  // R3 run 30
    {4'd3, 1'b1, 3'b000, 10'h3FF},  // R3 run 40
    {4'd3, 1'b1, 3'b000, 10'h3FF},  // R3 run 50
    {4'd3, 1'b0, 3'b000, 10'h3FF},  // R3 run 60 sets
    {4'd6, 1'b0, 3'b000, 10'h3FE},  // R6 good 1
    {4'd6, 1'b0, 3'b000, 10'h3FF},  // R6 quiet resets count
    {4'd6, 1'b0, 3'b000, 10'h3FE},  // R6 good 1
    {4'd6, 1'b0, 3'b000, 10'h3FE},  // R6 good 2
    {4'd6, 1'b1, 3'b000, 10'h3FE},  // R6 third clears, run 8
    {4'd2, 1'b1, 3'b000, 10'h000},  // R2 boundary change only, run 9
    {4'd4, 1'b1, 3'b000, 10'h000},  // R4 run 19
    {4'd4, 1'b1, 3'b000, 10'h000},  // R4 run 29
    {4'd4, 1'b1, 3'b000, 10'h000},  // R4 run 39
    {4'd4, 1'b1, 3'b000, 10'h000},  // R4 run 49
    {4'd2, 1'b1, 3'b000, 10'h000},  // R2 run 59
    {4'd3, 1'b0, 3'b000, 10'h000}   // R3 saturates at 60, sets
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] charIn = '0;
  logic       freqBad = 1'b0;
  logic       ampLow = 1'b0;
  logic       chanOff = 1'b0;
  logic       faultN;

  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  link_fault_monitor dut (
    .clk    (clk),
    .rstN   (rstN),
    .charIn (charIn),
    .freqBad(freqBad),
    .ampLow (ampLow),
    .chanOff(chanOff),
    .faultN (faultN)
  );

  task automatic checkOut(input logic exp, input int req, input int step);
    checks++;
    if (faultN !== exp) begin
      failures++;
      $display("FAIL R%0d step %0d: faultN=%b expected %b", req, step, faultN, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic applyRow(input logic [9:0] ch, input logic f, input logic a,
                          input logic o, input logic exp, input int req, input int step);
    charIn  = ch;
    freqBad = f;
    ampLow  = a;
    chanOff = o;
    @(posedge clk);
    #(PERIOD/4);
    checkOut(exp, req, step);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 5000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkOut(1'b0, 1, 0);
    rstN = 1'b1;

    for (int i = 0; i < NUM_VEC; i++) begin
      applyRow(VEC[i][9:0], VEC[i][10], VEC[i][11], VEC[i][12],
               VEC[i][13], int'(VEC[i][17:14]), i + 1);
    end

    // Clear again, then reset mid-operation (R1)
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b0, 5, 100);
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b0, 5, 101);
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b1, 5, 102);
    rstN = 1'b0;
    #(PERIOD/4);
    checkOut(1'b0, 1, 103);      // R1 asynchronous
    @(negedge clk);
    rstN = 1'b1;
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b0, 1, 104);  // R1 restarted count
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b0, 1, 105);
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b1, 1, 106);

    // R10: output holds until the capturing edge
    charIn  = 10'h155;
    freqBad = 1'b1;
    #(PERIOD/4);
    checkOut(1'b1, 10, 107);
    @(posedge clk);
    #(PERIOD/4);
    checkOut(1'b0, 10, 108);
    @(negedge clk);
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b1, 10, 109);

    // R9: disabled channel wins over an active stream
    applyRow(10'h155, 1'b0, 1'b0, 1'b1, 1'b0, 9, 110);
    applyRow(10'h155, 1'b0, 1'b0, 1'b1, 1'b0, 9, 111);
    applyRow(10'h155, 1'b0, 1'b0, 1'b0, 1'b1, 9, 112);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule